// File: doc/BRIEF.md
# Host Command and Completion Queue Register Block

This block sits on the device side of a host link and gives the host a small memory-mapped window for command submission and completion collection. The host writes a 32-bit command bus address into a request port; the word is queued in a request FIFO that the device's internal command logic drains through a valid/ready handshake. In the other direction, internal logic hands completion tags to a reply FIFO, and every host read of the reply port returns and removes the oldest tag. An empty reply queue reads back as all ones, so the host can poll without a separate status read.

Around the two queues the block provides an interrupt status register, an interrupt mask register whose polarity is inverted (zero enables), a host-writable doorbell word, a firmware-ready scratchpad and two read-only configuration pointers. It keeps a count of commands that have been posted and not yet completed, and flags when that count reaches a configured limit. A build parameter moves the pending/mask bit from bit 3 to bit 2 for the alternate register layout. Register reads are returned one clock after the access is presented.

Top module: `hostq_regif`

## Requirements
- R1: After reset the interrupt output is low, the status register (offset 0x30) reads zero, the mask register (offset 0x34) reads back with the mask bit set, and no request is offered to the internal side.
- R2: A host write to offset 0x40 queues the written 32-bit word; the internal side receives queued words in write order through `req_valid`/`req_ready`/`req_addr`, and reads of 0x40 return zero.
- R3: A host read of offset 0x44 returns the oldest tag accepted through `rsp_valid`/`rsp_ready`/`rsp_tag` and removes it, so successive reads return tags in arrival order.
- R4: A read of offset 0x44 while the reply queue is empty returns 0xFFFFFFFF and leaves the outstanding count and all queues unchanged.
- R5: The mask register holds one bit at the pending bit position; writing a word with that bit clear unmasks, writing it set masks. `irq` is high exactly when the reply queue is non-empty and the interrupt is unmasked, and follows a change of either one clock after the state register updates.
- R6: Status bit 3 (0x08) reports a non-empty reply queue in the default layout; with `ALT_LAYOUT` = 1 the pending and mask bit is bit 2 (0x04) instead, and bit 3 is then neither reported nor decoded.
- R7: An accepted request-port write raises the outstanding count by one and a reply read that returns a tag lowers it by one; status bit 1 and the `cmd_full` output are high while the count is at or above `MAX_OUT`.
- R8: A request-port write while the request queue is full is discarded (not queued, not counted) and sets status bit 0, which stays set until reset.
- R9: The scratchpad at offset 0xB0 reads 0xFFFF0000 while `fw_ready` is high and zero otherwise.
- R10: The doorbell at offset 0x20 is a 32-bit read/write word, reset to zero, whose value drives the `doorbell` output.
- R11: Offsets 0xB4 and 0xB8 read the parameters `CFG_TBL_PTR` and `CFG_MEM_OFS`; reads of any unmapped offset return zero, and writes to read-only offsets (0x30, 0x44, 0xB0, 0xB4, 0xB8) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| req_valid | output | 1 | A queued command address is available |
| req_ready | input | 1 | Internal side takes the offered address |
| req_addr | output | 32 | Oldest queued command address |
| rsp_valid | input | 1 | Internal side offers a completion tag |
| rsp_ready | output | 1 | Reply queue has space |
| rsp_tag | input | 32 | Completion tag |
| fw_ready | input | 1 | Internal initialisation complete |
| doorbell | output | 32 | Current doorbell word |
| cmd_full | output | 1 | Outstanding count at or above MAX_OUT |
| irq | output | 1 | Registered completion interrupt |

## Verification
Every bus access is presented at a falling edge and sampled at the next falling edge: read data is registered on the rising edge in between, so it is due exactly one cycle after the read, and queue, counter and mask state also change on that same edge. The interrupt adds one more register, so after a reply push, a mask write or the read that empties the queue the bench waits a further full cycle before sampling `irq`. A second instance built with the alternate layout shares all stimulus, so the moved status and mask bit is checked against the same traffic as the default one.

// File: rtl/hq_pkg.sv
package hq_pkg;
  localparam logic [7:0] OFS_DOORBELL = 8'h20;
  localparam logic [7:0] OFS_STATUS   = 8'h30;
  localparam logic [7:0] OFS_MASK     = 8'h34;
  localparam logic [7:0] OFS_REQUEST  = 8'h40;
  localparam logic [7:0] OFS_REPLY    = 8'h44;
  localparam logic [7:0] OFS_SCRATCH  = 8'hB0;
  localparam logic [7:0] OFS_CFG_TBL  = 8'hB4;
  localparam logic [7:0] OFS_CFG_MEM  = 8'hB8;

  localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;
  localparam logic [31:0] READY_WORD = 32'hFFFF_0000;

  localparam int STAT_OVF_BIT  = 0;
  localparam int STAT_FULL_BIT = 1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DOORBELL, SEL_STATUS, SEL_MASK, SEL_REQUEST,
    SEL_REPLY, SEL_SCRATCH, SEL_CFG_TBL, SEL_CFG_MEM
  } reg_sel_e;
endpackage

// File: rtl/hq_fifo.sv
module hq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill;
  logic             do_push, do_pop;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R8
  full_push_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (fill == $past(fill)));
  // R4
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (fill == $past(fill)));
endmodule

// File: rtl/hq_outstanding.sv
module hq_outstanding #(
  parameter int MAX_OUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_OUT + 1) + 1;
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc && !dec && cnt != TOP) begin
      cnt <= cnt + 1'b1;
    end else if (dec && !inc && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign at_limit = (cnt >= CW'(MAX_OUT));

  // R7
  cnt_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt == '0) |=> (cnt == '0));
  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/hq_irq.sv
module hq_irq (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic mask_we,
  input  logic mask_wbit,
  output logic masked,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      masked <= 1'b1;
      irq    <= 1'b0;
    end else begin
      if (mask_we) masked <= mask_wbit;
      irq <= pending && !masked;
    end
  end

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!$past(masked) && $past(pending)));
  // R1
  mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(masked) |-> $past(mask_we));
endmodule

// File: rtl/hostq_regif.sv
module hostq_regif
  import hq_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          REQ_DEPTH   = 16,
  parameter int          RSP_DEPTH   = 16,
  parameter int          MAX_OUT     = 16,
  parameter bit          ALT_LAYOUT  = 1'b0,
  parameter logic [31:0] CFG_TBL_PTR = 32'h0000_1000,
  parameter logic [31:0] CFG_MEM_OFS = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [31:0]       req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_tag,
  input  logic              fw_ready,
  output logic [31:0]       doorbell,
  output logic              cmd_full,
  output logic              irq
);
  localparam int PEND_BIT = ALT_LAYOUT ? 2 : 3;

  reg_sel_e    sel;
  logic        wr_acc, rd_acc;
  logic        req_push, req_full, req_empty, req_pop;
  logic        rsp_full, rsp_empty, rsp_pop;
  logic [31:0] rsp_head;
  logic        ovf_q, masked;
  logic [31:0] rd_next;

  always_comb begin
    case (8'(bus_addr))
      OFS_DOORBELL: sel = SEL_DOORBELL;
      OFS_STATUS:   sel = SEL_STATUS;
      OFS_MASK:     sel = SEL_MASK;
      OFS_REQUEST:  sel = SEL_REQUEST;
      OFS_REPLY:    sel = SEL_REPLY;
      OFS_SCRATCH:  sel = SEL_SCRATCH;
      OFS_CFG_TBL:  sel = SEL_CFG_TBL;
      OFS_CFG_MEM:  sel = SEL_CFG_MEM;
      default:      sel = SEL_NONE;
    endcase
  end

  assign wr_acc   = bus_sel && bus_we;
  assign rd_acc   = bus_sel && !bus_we;
  assign req_push = wr_acc && (sel == SEL_REQUEST);
  assign rsp_pop  = rd_acc && (sel == SEL_REPLY) && !rsp_empty;
  assign req_pop  = req_valid && req_ready;

  hq_fifo #(.WIDTH(32), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk(clk), .rst(rst),
    .push(req_push), .din(bus_wdata), .full(req_full),
    .pop(req_pop), .dout(req_addr), .empty(req_empty)
  );

  hq_fifo #(.WIDTH(32), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk(clk), .rst(rst),
    .push(rsp_valid), .din(rsp_tag), .full(rsp_full),
    .pop(rsp_pop), .dout(rsp_head), .empty(rsp_empty)
  );

  assign req_valid = !req_empty;
  assign rsp_ready = !rsp_full;

  hq_outstanding #(.MAX_OUT(MAX_OUT)) u_cnt (
    .clk(clk), .rst(rst),
    .inc(req_push && !req_full), .dec(rsp_pop),
    .at_limit(cmd_full)
  );

  hq_irq u_irq (
    .clk(clk), .rst(rst),
    .pending(!rsp_empty),
    .mask_we(wr_acc && (sel == SEL_MASK)),
    .mask_wbit(bus_wdata[PEND_BIT]),
    .masked(masked),
    .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q    <= 1'b0;
      doorbell <= '0;
    end else begin
      if (req_push && req_full) ovf_q <= 1'b1;
      if (wr_acc && sel == SEL_DOORBELL) doorbell <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_DOORBELL: rd_next = doorbell;
      SEL_STATUS: begin
        rd_next[STAT_OVF_BIT]  = ovf_q;
        rd_next[STAT_FULL_BIT] = cmd_full;
        rd_next[PEND_BIT]      = !rsp_empty;
      end
      SEL_MASK:    rd_next[PEND_BIT] = masked;
      SEL_REPLY:   rd_next = rsp_empty ? EMPTY_WORD : rsp_head;
      SEL_SCRATCH: rd_next = fw_ready ? READY_WORD : '0;
      SEL_CFG_TBL: rd_next = CFG_TBL_PTR;
      SEL_CFG_MEM: rd_next = CFG_MEM_OFS;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_next;
  end

  // R4
  empty_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && sel == SEL_REPLY && rsp_empty) |=> (bus_rdata == EMPTY_WORD));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && sel == SEL_NONE) |=> (bus_rdata == '0));
  // R2
  req_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (req_pop && !req_push) |=> !req_full);
endmodule

// File: tb/tb_hostq_regif.sv
module tb_hostq_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        req_ready = 0, rsp_valid = 0, fw_ready = 0;
  logic [31:0] rsp_tag = '0;
  logic [31:0] rdata_a, rdata_b, req_addr_a, req_addr_b, door_a, door_b;
  logic        req_valid_a, req_valid_b, rsp_ready_a, rsp_ready_b;
  logic        full_a, full_b, irq_a, irq_b;
  int checks = 0, errors = 0;

  localparam logic [31:0] TBL = 32'h0000_1000;
  localparam logic [31:0] MEM = 32'h0000_0200;

  always #2.5 clk = ~clk;

  hostq_regif #(.REQ_DEPTH(4), .RSP_DEPTH(4), .MAX_OUT(3), .ALT_LAYOUT(1'b0),
                .CFG_TBL_PTR(TBL), .CFG_MEM_OFS(MEM)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .req_valid(req_valid_a),
    .req_ready(req_ready), .req_addr(req_addr_a), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready_a), .rsp_tag(rsp_tag), .fw_ready(fw_ready),
    .doorbell(door_a), .cmd_full(full_a), .irq(irq_a));

  hostq_regif #(.REQ_DEPTH(4), .RSP_DEPTH(4), .MAX_OUT(3), .ALT_LAYOUT(1'b1),
                .CFG_TBL_PTR(TBL), .CFG_MEM_OFS(MEM)) dut_b (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .req_valid(req_valid_b),
    .req_ready(req_ready), .req_addr(req_addr_b), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready_b), .rsp_tag(rsp_tag), .fw_ready(fw_ready),
    .doorbell(door_b), .cmd_full(full_b), .irq(irq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    da = rdata_a; db = rdata_b;
    bus_sel = 0;
  endtask

  task automatic push_reply(input logic [31:0] t);
    @(negedge clk);
    rsp_valid = 1; rsp_tag = t;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic take_request(input string req, input logic [31:0] exp);
    @(negedge clk);
    chk({req, " req_valid"}, {31'd0, req_valid_a}, 32'd1);
    chk({req, " req_addr"}, req_addr_a, exp);
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    chk("R1 irq", {31'd0, irq_a}, 32'd0);
    chk("R1 req_valid", {31'd0, req_valid_a}, 32'd0);
    bus_read(8'h30, a, b);
    chk("R1 status", a, 32'h0);
    bus_read(8'h34, a, b);
    chk("R1 mask default", a, 32'h08);
    chk("R6 alt mask default", b, 32'h04);
    bus_read(8'h44, a, b);
    chk("R4 empty reply", a, 32'hFFFF_FFFF);
  endtask

  task automatic t_requests();
    logic [31:0] a, b;
    bus_write(8'h40, 32'hA000_0010);
    bus_write(8'h40, 32'hA000_0020);
    bus_read(8'h40, a, b);
    chk("R2 request port reads zero", a, 32'h0);
    bus_read(8'h30, a, b);
    chk("R7 count 2 not full", a, 32'h0);
    take_request("R2 first", 32'hA000_0010);
    take_request("R2 second", 32'hA000_0020);
    bus_write(8'h40, 32'hA000_0030);
    chk("R7 cmd_full at limit", {31'd0, full_a}, 32'd1);
    bus_read(8'h30, a, b);
    chk("R7 status full bit", a, 32'h02);
  endtask

  task automatic t_replies();
    logic [31:0] a, b;
    push_reply(32'h0000_0111);
    push_reply(32'h0000_0222);
    @(negedge clk);
    chk("R5 masked irq low", {31'd0, irq_a}, 32'd0);
    bus_read(8'h30, a, b);
    chk("R6 pending bit 3", a, 32'h0A);
    chk("R6 alt pending bit 2", b, 32'h06);
    bus_write(8'h34, 32'h0);
    @(negedge clk);
    chk("R5 unmasked irq high", {31'd0, irq_a}, 32'd1);
    chk("R6 alt unmasked irq high", {31'd0, irq_b}, 32'd1);
    bus_write(8'h34, 32'h08);
    @(negedge clk);
    chk("R5 remask irq low", {31'd0, irq_a}, 32'd0);
    chk("R6 alt ignores bit 3", {31'd0, irq_b}, 32'd1);
    bus_read(8'h34, a, b);
    chk("R5 mask readback", a, 32'h08);
    bus_write(8'h34, 32'h0);
    bus_read(8'h44, a, b);
    chk("R3 oldest tag", a, 32'h0000_0111);
    bus_read(8'h30, a, b);
    chk("R7 count drops below limit", a, 32'h08);
    bus_read(8'h44, a, b);
    chk("R3 second tag", a, 32'h0000_0222);
    @(negedge clk);
    chk("R5 irq clears on empty", {31'd0, irq_a}, 32'd0);
    bus_read(8'h44, a, b);
    chk("R4 empty after drain", a, 32'hFFFF_FFFF);
    bus_read(8'h30, a, b);
    chk("R4 empty read no state change", a, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] a, b;
    bus_write(8'h40, 32'hB000_0001);
    bus_write(8'h40, 32'hB000_0002);
    bus_write(8'h40, 32'hB000_0003);
    bus_write(8'h40, 32'hBAD0_0000);
    bus_read(8'h30, a, b);
    chk("R8 overflow sticky bit", a, 32'h03);
    take_request("R8 order 0", 32'hA000_0030);
    take_request("R8 order 1", 32'hB000_0001);
    take_request("R8 order 2", 32'hB000_0002);
    take_request("R8 order 3", 32'hB000_0003);
    @(negedge clk);
    chk("R8 dropped word absent", {31'd0, req_valid_a}, 32'd0);
    bus_read(8'h30, a, b);
    chk("R8 overflow remains", a[0 +: 1], 1'b1);
  endtask

  task automatic t_misc();
    logic [31:0] a, b;
    bus_write(8'h30, 32'h0);
    bus_read(8'h30, a, b);
    chk("R11 status write ignored", a, 32'h03);
    bus_read(8'h50, a, b);
    chk("R11 unmapped reads zero", a, 32'h0);
    bus_write(8'hB0, 32'h1234_5678);
    bus_read(8'hB0, a, b);
    chk("R9 scratch not ready", a, 32'h0);
    bus_write(8'h20, 32'hA5A5_0001);
    bus_read(8'h20, a, b);
    chk("R10 doorbell readback", a, 32'hA5A5_0001);
    chk("R10 doorbell port", door_a, 32'hA5A5_0001);
    fw_ready = 1;
    bus_read(8'hB0, a, b);
    chk("R9 scratch ready", a, 32'hFFFF_0000);
    bus_write(8'hB4, 32'h0);
    bus_read(8'hB4, a, b);
    chk("R11 cfg table ptr", a, TBL);
    bus_read(8'hB8, a, b);
    chk("R11 cfg mem offset", a, MEM);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_requests();
    t_replies();
    t_overflow();
    t_misc();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule